// File: doc/BRIEF.md
# Enhanced-Mode Register Bank with Parameter Memory

This block holds the registers that a dual-mode disk controller exposes once its legacy port has seen the unlock sequence. A one-cycle unlock pulse from the legacy detector makes this bank the responder and sets the mode-status bit (bit 6) of its mode register. From then on the host reaches a mode register, a phase register, a status byte and a sixteen-entry parameter memory. The register is selected by address bits 12 down to 9, so the bus address is shifted right by 9 to form the register index.

The mode register has no plain write path. One address clears the bits that are 1 in the written byte and another address sets them. A write to the clear address also moves the parameter pointer back to entry 0. If that write leaves bit 6 at 0, the bank goes idle and sends a one-cycle pulse that tells the legacy port to clear all of its latches. All parameter bytes are reached through a single port. Every read or write of that port steps a pointer that wraps after entry 15.

Each access is one plain bus beat: `acc_valid_i` together with `acc_write_i`, an address and write data. The bank never applies back-pressure, and the bus delivers at most one access per cycle. Read data comes back from a register on the cycle after the access, together with `rd_valid_o`.

Top module: `ebank_regs`

## Requirements
- R1: The register index is acc_addr_i[12:9]. Address bits below bit 9 are ignored. Write index codes: 0 data, 1 mark, 2 crc, 3 parameter, 4 phase, 5 setup, 6 mode-clear, 7 mode-set. Read index codes: 0 data, 1 mark, 2 error, 3 parameter, 4 phase, 5 setup, 6 status, 7 mode. Indices 8 to 15 do nothing on a write and read as 0.
- R2: A write to mode-clear (index 6) makes the mode register equal to mode & ~data.
- R3: A write to mode-set (index 7) makes the mode register equal to mode | data.
- R4: Every write to mode-clear resets the parameter pointer to 0, whatever the data.
- R5: If a mode-clear write leaves mode bit 6 at 0, enh_active_o falls on the next cycle and legacy_clr_o is 1 for exactly that one cycle. In every other case legacy_clr_o is 0.
- R6: The parameter memory has 16 bytes. A parameter write stores to entry [pointer] and a parameter read returns entry [pointer]. After either access the pointer steps by one, and it wraps from 15 to 0.
- R7: A status read returns the mode register with bit 6 replaced by the enhanced-active flag.
- R8: Writes to data, mark, crc and setup change no state. Reads of data, mark, error and setup return 0.
- R9: A write to phase (index 4) stores the byte, and the byte appears on phase_o and on phase reads.
- R10: An unlock_i pulse sets mode bit 6 and makes enh_active_o 1 on the next cycle. All other mode bits keep their values.
- R11: While enh_active_o is 0, accesses change no register or pointer, and reads return 0.
- R12: After reset, enh_active_o, legacy_clr_o, rd_valid_o, phase_o, the mode register and the pointer are all 0.
- R13: A read access gives rd_valid_o = 1, with its data on rd_data_o, in the next cycle. A write access gives rd_valid_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unlock_i | input | 1 | One-cycle unlock pulse from the legacy detector |
| acc_valid_i | input | 1 | Bus access present this cycle |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_addr_i | input | ADDR_W | Bus address; bits 12 to 9 select the register |
| acc_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | 8 | Read data |
| enh_active_o | output | 1 | Enhanced mode is active |
| legacy_clr_o | output | 1 | One-cycle pulse telling the legacy port to clear its latches |
| phase_o | output | 8 | Phase register contents |

## Verification
Every result of this bank is due exactly one clock edge after the access or unlock that causes it. This covers read data and rd_valid_o, the mode, phase and pointer updates, the drop of enh_active_o and the legacy_clr_o pulse. The bench drives each beat on a falling edge and samples all outputs on the next falling edge. A reference model advances in lockstep with each beat, so every comparison uses the value due in that cycle. Because legacy_clr_o lasts only one cycle, it is compared after every beat, so a missing, late or extra pulse is caught.

// File: rtl/ebank_pkg.sv
package ebank_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned SEL_LSB  = 9;
  localparam int unsigned STAT_BIT = 6;

  // write index codes
  localparam logic [SEL_W-1:0] W_DATA  = 4'd0;
  localparam logic [SEL_W-1:0] W_MARK  = 4'd1;
  localparam logic [SEL_W-1:0] W_CRC   = 4'd2;
  localparam logic [SEL_W-1:0] W_PARAM = 4'd3;
  localparam logic [SEL_W-1:0] W_PHASE = 4'd4;
  localparam logic [SEL_W-1:0] W_SETUP = 4'd5;
  localparam logic [SEL_W-1:0] W_MCLR  = 4'd6;
  localparam logic [SEL_W-1:0] W_MSET  = 4'd7;

  // read index codes
  localparam logic [SEL_W-1:0] R_PARAM  = 4'd3;
  localparam logic [SEL_W-1:0] R_PHASE  = 4'd4;
  localparam logic [SEL_W-1:0] R_STATUS = 4'd6;
  localparam logic [SEL_W-1:0] R_MODE   = 4'd7;

  typedef struct packed {
    logic wr_clr;
    logic wr_set;
    logic wr_param;
    logic wr_phase;
    logic rd_param;
    logic rd_phase;
    logic rd_status;
    logic rd_mode;
  } strobe_t;
endpackage

// File: rtl/ebank_decode.sv
module ebank_decode
  import ebank_pkg::*;
(
  input  logic             valid,
  input  logic             write,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output strobe_t          strb
);
  logic wr_ok, rd_ok;

  assign wr_ok = valid & write & active;
  assign rd_ok = valid & ~write & active;

  always_comb begin
    strb           = '0;
    strb.wr_clr    = wr_ok & (sel == W_MCLR);
    strb.wr_set    = wr_ok & (sel == W_MSET);
    strb.wr_param  = wr_ok & (sel == W_PARAM);
    strb.wr_phase  = wr_ok & (sel == W_PHASE);
    strb.rd_param  = rd_ok & (sel == R_PARAM);
    strb.rd_phase  = rd_ok & (sel == R_PHASE);
    strb.rd_status = rd_ok & (sel == R_STATUS);
    strb.rd_mode   = rd_ok & (sel == R_MODE);
  end
endmodule

// File: rtl/ebank_mode.sv
module ebank_mode
  import ebank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock,
  input  logic              wr_clr,
  input  logic              wr_set,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_q,
  output logic              active_q,
  output logic              legacy_clr_q
);
  logic [DATA_W-1:0] cleared;

  assign cleared = mode_q & ~wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= '0;
      active_q     <= 1'b0;
      legacy_clr_q <= 1'b0;
    end else begin
      legacy_clr_q <= 1'b0;
      if (unlock) begin
        mode_q[STAT_BIT] <= 1'b1;
        active_q         <= 1'b1;
      end else if (wr_clr) begin
        mode_q <= cleared;
        if (!cleared[STAT_BIT]) begin
          active_q     <= 1'b0;
          legacy_clr_q <= 1'b1;
        end
      end else if (wr_set) begin
        mode_q <= mode_q | wdata;
      end
    end
  end
endmodule

// File: rtl/ebank_pram.sv
module ebank_pram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic          idx_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [IW-1:0] idx_q
);
  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx_nxt;

  assign idx_nxt = (idx_q == IW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
  assign rdata   = mem[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_clr) begin
      idx_q <= '0;
    end else if (wr || rd) begin
      idx_q <= idx_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[idx_q] <= wdata;
  end
endmodule

// File: rtl/ebank_regs.sv
module ebank_regs
  import ebank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned PRAM_DEPTH = 16,
  localparam int unsigned PIW       = $clog2(PRAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [7:0]        acc_wdata_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              enh_active_o,
  output logic              legacy_clr_o,
  output logic [7:0]        phase_o
);
  logic [SEL_W-1:0]  sel;
  strobe_t           strb;
  logic [DATA_W-1:0] mode_w;
  logic              active_w;
  logic [DATA_W-1:0] pram_rdata;
  logic [PIW-1:0]    pidx_w;
  logic [DATA_W-1:0] phase_q;
  logic [DATA_W-1:0] status_w;

  assign sel = acc_addr_i[SEL_LSB +: SEL_W];

  ebank_decode u_dec (
    .valid  (acc_valid_i),
    .write  (acc_write_i),
    .active (active_w),
    .sel    (sel),
    .strb   (strb)
  );

  ebank_mode u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .unlock       (unlock_i),
    .wr_clr       (strb.wr_clr),
    .wr_set       (strb.wr_set),
    .wdata        (acc_wdata_i),
    .mode_q       (mode_w),
    .active_q     (active_w),
    .legacy_clr_q (legacy_clr_o)
  );

  ebank_pram #(.DEPTH(PRAM_DEPTH), .DW(DATA_W)) u_pram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (strb.wr_param),
    .rd      (strb.rd_param),
    .idx_clr (strb.wr_clr),
    .wdata   (acc_wdata_i),
    .rdata   (pram_rdata),
    .idx_q   (pidx_w)
  );

  always_comb begin
    status_w           = mode_w;
    status_w[STAT_BIT] = active_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      if (strb.wr_phase) phase_q <= acc_wdata_i;
      rd_valid_o <= acc_valid_i & ~acc_write_i;
      unique case (1'b1)
        strb.rd_param:  rd_data_o <= pram_rdata;
        strb.rd_phase:  rd_data_o <= phase_q;
        strb.rd_status: rd_data_o <= status_w;
        strb.rd_mode:   rd_data_o <= mode_w;
        default:        rd_data_o <= '0;
      endcase
    end
  end

  assign enh_active_o = active_w;
  assign phase_o      = phase_q;
endmodule

// File: rtl/ebank_regs_chk.sv
module ebank_regs_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PIW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unlock_i,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [7:0]        acc_wdata_i,
  input logic              rd_valid_o,
  input logic [7:0]        rd_data_o,
  input logic              enh_active_o,
  input logic              legacy_clr_o,
  input logic [7:0]        mode_w,
  input logic [PIW-1:0]    pidx_w
);
  logic [3:0] s;
  logic       wbeat, rbeat;
  assign s     = acc_addr_i[12:9];
  assign wbeat = acc_valid_i & acc_write_i & enh_active_o & ~unlock_i;
  assign rbeat = acc_valid_i & ~acc_write_i & enh_active_o & ~unlock_i;

  a_r2_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wbeat && s == 4'd6 |=> mode_w == ($past(mode_w) & ~$past(acc_wdata_i)));
  a_r3_mode_set: assert property (@(posedge clk) disable iff (!rst_n)
    wbeat && s == 4'd7 |=> mode_w == ($past(mode_w) | $past(acc_wdata_i)));
  a_r4_index_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wbeat && s == 4'd6 |=> pidx_w == '0);
  a_r5_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wbeat && s == 4'd6 && !(mode_w[6] & ~acc_wdata_i[6]) |=> !enh_active_o && legacy_clr_o);
  a_r5_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_clr_o |=> !legacy_clr_o);
  a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && enh_active_o && !unlock_i && s == 4'd3 |=> pidx_w == $past(pidx_w) + 1'b1);
  a_r7_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rbeat && s == 4'd6 |=> rd_data_o[6]);
  a_r10_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_i |=> enh_active_o && mode_w[6]);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_active_o && !unlock_i |=> $stable(mode_w) && $stable(pidx_w));
  a_r13_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && !acc_write_i |=> rd_valid_o);
endmodule

bind ebank_regs ebank_regs_chk #(.ADDR_W(ADDR_W), .PIW(PIW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .unlock_i     (unlock_i),
  .acc_valid_i  (acc_valid_i),
  .acc_write_i  (acc_write_i),
  .acc_addr_i   (acc_addr_i),
  .acc_wdata_i  (acc_wdata_i),
  .rd_valid_o   (rd_valid_o),
  .rd_data_o    (rd_data_o),
  .enh_active_o (enh_active_o),
  .legacy_clr_o (legacy_clr_o),
  .mode_w       (mode_w),
  .pidx_w       (pidx_w)
);

// File: tb/ebank_regs_tb.sv
`timescale 1ns/1ps
module ebank_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unlock_i = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [12:0] acc_addr_i = '0;
  logic [7:0]  acc_wdata_i = '0;
  logic        rd_valid_o, enh_active_o, legacy_clr_o;
  logic [7:0]  rd_data_o, phase_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_mode;
  bit         m_act;
  logic [3:0] m_idx;
  logic [7:0] m_pram [16];
  logic [7:0] m_phase;

  always #2 clk = ~clk;

  ebank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
    .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .enh_active_o(enh_active_o), .legacy_clr_o(legacy_clr_o),
    .phase_o(phase_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] s);
    logic [7:0] v;
    if (!m_act) return 8'h00;
    case (s)
      4'd3: v = m_pram[m_idx];
      4'd4: v = m_phase;
      4'd6: begin v = m_mode; v[6] = m_act; end
      4'd7: v = m_mode;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // one bus beat; model updated and all outputs compared one edge later
  task automatic beat(input bit wr, input logic [3:0] s, input logic [7:0] d, input string req);
    logic [7:0] exp_rd;
    bit exp_lc;
    exp_rd = model_read(s);
    exp_lc = 0;
    if (m_act) begin
      if (wr) begin
        case (s)
          4'd3: begin m_pram[m_idx] = d; m_idx = m_idx + 1; end
          4'd4: m_phase = d;
          4'd6: begin
            m_mode = m_mode & ~d; m_idx = 0;
            if (!m_mode[6]) begin m_act = 0; exp_lc = 1; end
          end
          4'd7: m_mode = m_mode | d;
          default: ;
        endcase
      end else if (s == 4'd3) begin
        m_idx = m_idx + 1;
      end
    end
    acc_valid_i = 1'b1;
    acc_write_i = wr;
    acc_addr_i  = {s, 9'($urandom)};   // R1: low bits are don't-care
    acc_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    acc_valid_i = 1'b0;
    chk({req, " R13 rd_valid"}, rd_valid_o, !wr);
    if (!wr) chk({req, " R1 read data"}, rd_data_o, exp_rd);
    chk({req, " R5 legacy_clr"}, legacy_clr_o, exp_lc);
    chk({req, " active"}, enh_active_o, m_act);
    chk({req, " R9 phase_o"}, phase_o, m_phase);
  endtask

  task automatic do_unlock();
    unlock_i = 1'b1;
    m_mode[6] = 1'b1;
    m_act = 1;
    @(posedge clk);
    @(negedge clk);
    unlock_i = 1'b0;
    chk("R10 active after unlock", enh_active_o, 1'b1);
    chk("R10 no clear pulse", legacy_clr_o, 1'b0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] seed_v;
    seed_v = 8'($urandom(32'd1234));
    m_mode = 0; m_act = 0; m_idx = 0; m_phase = 0;
    for (int i = 0; i < 16; i++) m_pram[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 active", enh_active_o, 1'b0);
    chk("R12 legacy_clr", legacy_clr_o, 1'b0);
    chk("R12 rd_valid", rd_valid_o, 1'b0);
    chk("R12 phase", phase_o, 8'h00);

    // R11 ignored while legacy
    beat(1, 4'd7, 8'h3C, "R11 set idle");
    beat(1, 4'd4, 8'h99, "R11 phase idle");
    beat(1, 4'd3, 8'h55, "R11 param idle");
    beat(0, 4'd6, 8'h00, "R11 status idle");

    do_unlock();
    beat(0, 4'd7, 8'h00, "R10 mode after unlock");
    beat(0, 4'd6, 8'h00, "R7 status");

    // R6 fill memory, wrap, read back
    for (int i = 0; i < 18; i++) beat(1, 4'd3, 8'(8'hA0 + i), "R6 param write");
    beat(1, 4'd6, 8'h00, "R4 clear resets index");
    for (int i = 0; i < 17; i++) beat(0, 4'd3, 8'h00, "R6 param read");

    // R2/R3/R7
    beat(1, 4'd7, 8'h8F, "R3 set");
    beat(0, 4'd7, 8'h00, "R3 readback");
    beat(1, 4'd6, 8'h05, "R2 clear");
    beat(0, 4'd7, 8'h00, "R2 readback");
    beat(0, 4'd6, 8'h00, "R7 status mix");
    beat(1, 4'd4, 8'h5A, "R9 phase write");
    beat(0, 4'd4, 8'h00, "R9 phase read");

    // R8 ignored registers
    beat(1, 4'd0, 8'hFF, "R8 data");
    beat(1, 4'd1, 8'hFF, "R8 mark");
    beat(1, 4'd2, 8'hFF, "R8 crc");
    beat(1, 4'd5, 8'hFF, "R8 setup");
    beat(1, 4'd12, 8'hFF, "R1 unused idx");
    for (int s = 0; s < 16; s++) beat(0, 4'(s), 8'h00, "R8 read map");

    // R5 return to legacy, then R11 hold and re-entry
    beat(1, 4'd6, 8'h40, "R5 drop");
    beat(1, 4'd4, 8'h11, "R11 phase while legacy");
    do_unlock();
    beat(0, 4'd7, 8'h00, "R10 mode kept bits");
    beat(0, 4'd4, 8'h00, "R11 phase kept");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] s;
      logic [7:0] d;
      s = 4'($urandom_range(0, 8));
      d = 8'($urandom);
      if (s == 4'd6 && $urandom_range(0, 3) != 0) d[6] = 1'b0;
      if (!m_act && $urandom_range(0, 2) == 0) do_unlock();
      else beat($urandom_range(0, 1) == 1, s, d, "R6 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule